// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block sits on the memory access path of a host bridge and classifies every access that falls in the old adapter and BIOS area of the first megabyte, from 0xA0000 up to 0xFFFFF. For each access it reports one of four route codes: system RAM with reads and writes, system RAM with reads only, forward to the legacy expansion bus, or pass-through for addresses outside the area. A write-block flag is raised when a write lands on a read-only RAM segment.

The routing comes from two-bit attribute fields held in seven configuration bytes. One field covers the whole 64 KB top segment, and twelve fields cover the 16 KB segments between 0xC0000 and 0xEFFFF, packed two to a byte. A separate control byte opens the 128 KB graphics window at 0xA0000 to RAM, either always or only while the system-management mode input is high. The configuration bytes are written through a byte-wide write port. The decision is registered and appears one cycle after the access is presented.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset all attribute fields are 0 and the control byte is 0x02, so every access in 0xA0000–0xFFFFF routes to the legacy bus (code 3), even with the mode input high. out_valid, out_route and out_wblock are 0 during and straight after reset.
- R2: Accesses in 0xF0000–0xFFFFF take their attribute from bits 5:4 of the byte at offset 0x59. The other bits of that byte do not affect routing.
- R3: Segment i (0..11) covers 0xC0000 + i*0x4000 for 16 KB. It takes its attribute from the byte at offset 0x5A + i/2, from bits 1:0 when i is even and from bits 5:4 when i is odd.
- R4: Attribute 3 gives route code 1 (RAM read/write), and out_wblock is 0 for reads and writes.
- R5: Attribute 1 gives route code 2 (RAM read-only). out_wblock is 1 for a write and 0 for a read.
- R6: Attributes 0 and 2 give route code 3 (legacy bus) with out_wblock 0.
- R7: Accesses in 0xA0000–0xBFFFF give route code 1 when bit 6 of the byte at offset 0x72 is set, or when the mode input is high and bit 3 of that byte is set. Otherwise they give route code 3. out_wblock is 0.
- R8: Accesses below 0xA0000 give route code 0 (pass-through) and never set out_wblock.
- R9: out_valid is high in exactly the cycle after acc_valid was high. out_route and out_wblock in that cycle describe that access.
- R10: A configuration write takes effect for accesses presented from the next cycle on. The mode input acts on the access presented in the same cycle. Writes to offsets other than 0x59–0x5F and 0x72 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 20 | Access byte address |
| acc_write | input | 1 | 1 for write, 0 for read |
| smm_active | input | 1 | System-management mode level |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_offset | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| out_valid | output | 1 | Decision valid (one cycle after access) |
| out_route | output | 2 | 0 pass, 1 RAM rw, 2 RAM ro, 3 legacy bus |
| out_wblock | output | 1 | Write to read-only RAM blocked |

## Verification
A vector table walks the top segment, the first and last of the twelve small segments and a middle pair, the graphics window and addresses below it. Each attribute value is tried with both reads and writes. Odd and even segments sharing one byte are given different attributes, so a swapped nibble shows up. Attribute bytes are written with bits set outside the used field, so a wrong bit slice shows up. The graphics window is tried under each control-bit and mode-input combination, which separates the unconditional open from the mode-gated open. Directed tests flip the mode input on back-to-back accesses, write and access in the same cycle, and reset in the middle of a run.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  typedef enum logic [1:0] {
    ROUTE_PASS   = 2'd0,
    ROUTE_RAM_RW = 2'd1,
    ROUTE_RAM_RO = 2'd2,
    ROUTE_LEGACY = 2'd3
  } route_e;

  localparam logic [1:0] ATTR_RAM_RO = 2'd1;
  localparam logic [1:0] ATTR_RAM_RW = 2'd3;

  function automatic route_e attr_to_route(input logic [1:0] attr);
    case (attr)
      ATTR_RAM_RW: attr_to_route = ROUTE_RAM_RW;
      ATTR_RAM_RO: attr_to_route = ROUTE_RAM_RO;
      default:     attr_to_route = ROUTE_LEGACY;
    endcase
  endfunction

endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs #(
  parameter int         SEG_COUNT     = 12,
  parameter logic [7:0] TOP_OFF       = 8'h59,
  parameter int         TOP_LSB       = 4,
  parameter logic [7:0] SEG_BASE_OFF  = 8'h5A,
  parameter logic [7:0] SMRAM_OFF     = 8'h72,
  parameter logic [7:0] SMRAM_RST     = 8'h02
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_offset,
  input  logic [7:0]           cfg_wdata,
  output logic [1:0]           top_attr,
  output logic [SEG_COUNT-1:0][1:0] seg_attr,
  output logic                 smram_open,
  output logic                 smram_smm_en
);

  localparam int OPEN_BIT = 6;
  localparam int SMM_BIT  = 3;

  logic [7:0] smram_q;

  // top segment field
  always_ff @(posedge clk) begin
    if (rst)
      top_attr <= 2'd0;
    else if (cfg_we && cfg_offset == TOP_OFF)
      top_attr <= cfg_wdata[TOP_LSB +: 2];
  end

  // packed segment fields, two per byte
  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
    localparam logic [7:0] BYTE_OFF = 8'(int'(SEG_BASE_OFF) + i / 2);
    localparam int         LSB      = (i % 2) * 4;
    always_ff @(posedge clk) begin
      if (rst)
        seg_attr[i] <= 2'd0;
      else if (cfg_we && cfg_offset == BYTE_OFF)
        seg_attr[i] <= cfg_wdata[LSB +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      smram_q <= SMRAM_RST;
    else if (cfg_we && cfg_offset == SMRAM_OFF)
      smram_q <= cfg_wdata;
  end

  assign smram_open   = smram_q[OPEN_BIT];
  assign smram_smm_en = smram_q[SMM_BIT];

  // R1: control byte comes out of reset at its defined value
  p_smram_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> smram_q == SMRAM_RST);

  // R10: a write to an unrelated offset leaves the top field unchanged
  p_top_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_offset != TOP_OFF) |=> $stable(top_attr));

endmodule

// File: rtl/lmr_decode.sv
module lmr_decode
  import lmr_pkg::*;
#(
  parameter int         ADDR_W    = 20,
  parameter int         SEG_COUNT = 12,
  parameter int         SEG_SHIFT = 14,
  parameter logic [19:0] VGA_BASE = 20'hA0000,
  parameter logic [19:0] SEG_BASE = 20'hC0000,
  parameter logic [19:0] TOP_BASE = 20'hF0000
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        write,
  input  logic                        smm,
  input  logic [1:0]                  top_attr,
  input  logic [SEG_COUNT-1:0][1:0]   seg_attr,
  input  logic                        smram_open,
  input  logic                        smram_smm_en,
  output route_e                      route,
  output logic                        wblock
);

  localparam int IDX_W   = $clog2(SEG_COUNT);
  localparam int IDX_N   = 1 << IDX_W;

  logic [ADDR_W-1:0]   seg_off;
  logic [IDX_W-1:0]    seg_idx;
  logic [IDX_N-1:0][1:0] seg_tab;
  logic                in_vga, in_seg, in_top;
  route_e              route_c;

  // pad the segment table to a power of two
  for (genvar i = 0; i < IDX_N; i++) begin : g_tab
    if (i < SEG_COUNT) begin : g_used
      assign seg_tab[i] = seg_attr[i];
    end else begin : g_pad
      assign seg_tab[i] = 2'd0;
    end
  end

  assign in_top  = addr >= TOP_BASE;
  assign in_seg  = (addr >= SEG_BASE) && !in_top;
  assign in_vga  = (addr >= VGA_BASE) && (addr < SEG_BASE);
  assign seg_off = addr - SEG_BASE;
  assign seg_idx = seg_off[SEG_SHIFT +: IDX_W];

  always_comb begin
    if (in_top)
      route_c = attr_to_route(top_attr);
    else if (in_seg)
      route_c = attr_to_route(seg_tab[seg_idx]);
    else if (in_vga)
      route_c = (smram_open || (smm && smram_smm_en)) ? ROUTE_RAM_RW : ROUTE_LEGACY;
    else
      route_c = ROUTE_PASS;
  end

  assign route  = route_c;
  assign wblock = write && (route_c == ROUTE_RAM_RO);

  // R8: below the window never routes to RAM or legacy
  always_comb begin
    if (!in_vga && !in_seg && !in_top)
      a_pass_r8: assert (route == ROUTE_PASS && !wblock);
  end

endmodule

// File: rtl/lmr_route_reg.sv
module lmr_route_reg
  import lmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   in_valid,
  input  route_e in_route,
  input  logic   in_wblock,
  output logic   out_valid,
  output logic [1:0] out_route,
  output logic   out_wblock
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_route  <= ROUTE_PASS;
      out_wblock <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_route  <= in_valid ? in_route : ROUTE_PASS;
      out_wblock <= in_valid && in_wblock;
    end
  end

  // R9: one-cycle latency of the valid marker
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_follows_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_wblock);

endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
  import lmr_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_COUNT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              smm_active,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_offset,
  input  logic [7:0]        cfg_wdata,
  output logic              out_valid,
  output logic [1:0]        out_route,
  output logic              out_wblock
);

  logic [1:0]                 top_attr;
  logic [SEG_COUNT-1:0][1:0]  seg_attr;
  logic                       smram_open, smram_smm_en;
  route_e                     dec_route;
  logic                       dec_wblock;

  lmr_cfg_regs #(.SEG_COUNT(SEG_COUNT)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_offset   (cfg_offset),
    .cfg_wdata    (cfg_wdata),
    .top_attr     (top_attr),
    .seg_attr     (seg_attr),
    .smram_open   (smram_open),
    .smram_smm_en (smram_smm_en)
  );

  lmr_decode #(.ADDR_W(ADDR_W), .SEG_COUNT(SEG_COUNT)) u_dec (
    .addr         (acc_addr),
    .write        (acc_write),
    .smm          (smm_active),
    .top_attr     (top_attr),
    .seg_attr     (seg_attr),
    .smram_open   (smram_open),
    .smram_smm_en (smram_smm_en),
    .route        (dec_route),
    .wblock       (dec_wblock)
  );

  lmr_route_reg u_out (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (acc_valid),
    .in_route   (dec_route),
    .in_wblock  (dec_wblock),
    .out_valid  (out_valid),
    .out_route  (out_route),
    .out_wblock (out_wblock)
  );

  // R5: a blocked write must come from a write access
  p_block_is_write_r5: assert property (@(posedge clk) disable iff (rst)
    out_wblock |-> $past(acc_write) && $past(acc_valid));

  // R5: blocking only happens on the read-only route
  p_block_route_r5: assert property (@(posedge clk) disable iff (rst)
    out_wblock |-> out_route == ROUTE_RAM_RO);

  // R7: closed graphics window forwards to the legacy bus
  p_vga_closed_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_addr >= 20'hA0000 && acc_addr < 20'hC0000 &&
     !smram_open && !(smm_active && smram_smm_en))
    |=> out_route == ROUTE_LEGACY && !out_wblock);

endmodule

// File: tb/legacy_mem_router_tb_top.sv
module legacy_mem_router_tb_top;

  logic clk = 1'b0;
  logic rst;
  logic acc_valid, acc_write, smm_active, cfg_we;
  logic [19:0] acc_addr;
  logic [7:0] cfg_offset, cfg_wdata;
  logic out_valid, out_wblock;
  logic [1:0] out_route;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  legacy_mem_router dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .smm_active(smm_active), .cfg_we(cfg_we),
    .cfg_offset(cfg_offset), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
    .out_route(out_route), .out_wblock(out_wblock)
  );

  // fields: off[40:33] data[32:25] addr[24:5] wr[4] smm[3] route[2:1] blk[0]
  // off 0 means no configuration write before the access
  localparam int NV = 23;
  localparam logic [40:0] VEC [NV] = '{
    {8'h00, 8'h00, 20'hF0000, 1'b0, 1'b0, 2'd3, 1'b0}, // R1
    {8'h00, 8'h00, 20'hC0000, 1'b1, 1'b0, 2'd3, 1'b0}, // R1
    {8'h00, 8'h00, 20'hA0000, 1'b0, 1'b1, 2'd3, 1'b0}, // R1 mode high, window shut
    {8'h00, 8'h00, 20'h90000, 1'b1, 1'b0, 2'd0, 1'b0}, // R8
    {8'h59, 8'h30, 20'hFFFFF, 1'b1, 1'b0, 2'd1, 1'b0}, // R2 R4
    {8'h59, 8'h10, 20'hF8000, 1'b1, 1'b0, 2'd2, 1'b1}, // R2 R5
    {8'h00, 8'h00, 20'hF8000, 1'b0, 1'b0, 2'd2, 1'b0}, // R5 read
    {8'h59, 8'h20, 20'hF0000, 1'b0, 1'b0, 2'd3, 1'b0}, // R6 attr 2
    {8'h59, 8'h03, 20'hF0000, 1'b1, 1'b0, 2'd3, 1'b0}, // R2 low bits ignored
    {8'h5A, 8'h13, 20'hC0000, 1'b1, 1'b0, 2'd1, 1'b0}, // R3 seg0 even
    {8'h00, 8'h00, 20'hC4000, 1'b1, 1'b0, 2'd2, 1'b1}, // R3 seg1 odd
    {8'h00, 8'h00, 20'hC7FFF, 1'b0, 1'b0, 2'd2, 1'b0}, // R3 seg1 top byte
    {8'h5F, 8'hC1, 20'hE8000, 1'b1, 1'b0, 2'd2, 1'b1}, // R3 seg10
    {8'h00, 8'h00, 20'hEC000, 1'b0, 1'b0, 2'd3, 1'b0}, // R3 seg11 masked 0
    {8'h5C, 8'h07, 20'hD0000, 1'b1, 1'b0, 2'd1, 1'b0}, // R3 seg4 masked 3
    {8'h00, 8'h00, 20'hD4000, 1'b1, 1'b0, 2'd3, 1'b0}, // R3 R6 seg5
    {8'h72, 8'h08, 20'hA0000, 1'b0, 1'b0, 2'd3, 1'b0}, // R7 mode low
    {8'h00, 8'h00, 20'hBFFFF, 1'b1, 1'b1, 2'd1, 1'b0}, // R7 mode high
    {8'h72, 8'h40, 20'hB0000, 1'b1, 1'b0, 2'd1, 1'b0}, // R7 open bit
    {8'h58, 8'hFF, 20'hF0000, 1'b0, 1'b0, 2'd3, 1'b0}, // R10 stray offset
    {8'h00, 8'h00, 20'h00000, 1'b1, 1'b1, 2'd0, 1'b0}, // R8
    {8'h00, 8'h00, 20'h9FFFF, 1'b1, 1'b0, 2'd0, 1'b0}, // R8 edge
    {8'h00, 8'h00, 20'hEFFFF, 1'b0, 1'b0, 2'd3, 1'b0}  // R3 seg11 end
  };

  function automatic string tag_of(input logic [19:0] a);
    if (a < 20'hA0000)      return "R8";
    else if (a < 20'hC0000) return "R7";
    else if (a < 20'hF0000) return "R3";
    else                    return "R2";
  endfunction

  task automatic check(input string req, input logic v, input logic [1:0] r,
                       input logic b, input logic ev, input logic [1:0] er,
                       input logic eb);
    n_tests++;
    if (v !== ev || r !== er || b !== eb) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b route=%0d wblock=%0b, expected valid=%0b route=%0d wblock=%0b",
               req, v, r, b, ev, er, eb);
    end
  endtask

  task automatic idle();
    acc_valid = 1'b0; acc_write = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    idle();
    cfg_we = 1'b1; cfg_offset = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic access(input logic [19:0] a, input logic w, input logic s,
                        input string req, input logic [1:0] er, input logic eb);
    acc_valid = 1'b1; acc_addr = a; acc_write = w; smm_active = s;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, out_valid, out_route, out_wblock, 1'b1, er, eb);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; idle(); acc_addr = '0; smm_active = 1'b0;
    cfg_offset = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", out_valid, out_route, out_wblock, 1'b0, 2'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", out_valid, out_route, out_wblock, 1'b0, 2'd0, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      string t;
      v = VEC[i];
      if (v[40:33] != 8'h00) cfg_wr(v[40:33], v[32:25]);
      else @(negedge clk);
      t = $sformatf("%s/R4/R5/R6 vec %0d", tag_of(v[24:5]), i);
      access(v[24:5], v[4], v[3], t, v[2:1], v[0]);
    end

    // R9: idle cycle carries no decision
    @(negedge clk);
    check("R9 idle", out_valid, out_route, out_wblock, 1'b0, 2'd0, 1'b0);

    // R10: mode input acts on back-to-back accesses in the same cycle
    cfg_wr(8'h72, 8'h08);
    acc_valid = 1'b1; acc_addr = 20'hA8000; acc_write = 1'b1; smm_active = 1'b1;
    @(negedge clk);
    check("R10 mode high", out_valid, out_route, out_wblock, 1'b1, 2'd1, 1'b0);
    smm_active = 1'b0;
    @(negedge clk);
    check("R10 mode low", out_valid, out_route, out_wblock, 1'b1, 2'd3, 1'b0);
    idle();

    // R10: write and access in the same cycle sees the old field
    cfg_wr(8'h59, 8'h30);
    cfg_we = 1'b1; cfg_offset = 8'h59; cfg_wdata = 8'h10;
    acc_valid = 1'b1; acc_addr = 20'hF4000; acc_write = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R10 same cycle", out_valid, out_route, out_wblock, 1'b1, 2'd1, 1'b0);
    @(negedge clk);
    check("R10 next cycle", out_valid, out_route, out_wblock, 1'b1, 2'd2, 1'b1);
    idle();

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    access(20'hF4000, 1'b1, 1'b0, "R1 top after rerun", 2'd3, 1'b0);
    access(20'hC4000, 1'b1, 1'b0, "R1 seg after rerun", 2'd3, 1'b0);
    access(20'hA0000, 1'b0, 1'b1, "R1 window after rerun", 2'd3, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule